// File: doc/BRIEF.md
# Rotate-Left-Through-Carry Register Unit

This block executes one instruction: rotate an 8-bit data-memory operand one place to the left through the carry flag. It decodes a 16-bit instruction word and takes two control bits from it. The bank-select bit chooses between a fixed split "quick" bank and the bank held in the bank register. The destination bit chooses between the working register and the memory location the operand came from. The unit then forms a 12-bit data address and reads the operand through a synchronous RAM port. It computes the rotated value and, in one final cycle, drives the write for the chosen destination and the new carry, negative and zero flags.

The working register and the status register sit outside the block. The carry input is sampled when an instruction is accepted. The results come out as data buses with single-cycle write strobes. An instruction is offered by pulsing `start` while `busy` is low. The unit goes through four phases: accept, read, compute and write. It then returns to idle.

Top module: `rlcf_unit`

## Requirements
- R1: An instruction is accepted only when `start` is high, `busy` is low and `instr[15:10]` equals 6'b001101. Any other opcode leaves `busy` low and raises none of `ram_we`, `w_we` or `flag_we`.
- R2: The result takes old bit n into bit n+1 for n = 0..6, and the carry sampled at acceptance into bit 0. The new carry equals old bit 7.
- R3: With `instr[9]` (destination bit) = 0 the result is written to the working register (`w_we` pulse, `w_data`) and memory is not written. With `instr[9]` = 1 the result is written back to the operand address (`ram_we` pulse, `ram_wdata`) and `w_we` stays low.
- R4: With `instr[8]` (bank bit) = 1 the address is {`bsr[3:0]`, `instr[7:0]`}. With `instr[8]` = 0, `bsr` is ignored: offsets 0x00–0x5F map to bank 0x0 and offsets 0x60–0xFF map to bank 0xF.
- R5: In the write cycle `c_out` carries the new carry, `n_out` equals bit 7 of the result, and `z_out` is 1 exactly when the 8-bit result is zero.
- R6: The read address is on `ram_addr` with `ram_re` high in the first cycle after acceptance. The operand is expected on `ram_rdata` in the second cycle. `flag_we` and the destination strobe pulse for exactly one cycle, in the third cycle after acceptance.
- R7: After reset `busy`, `ram_re`, `ram_we`, `w_we` and `flag_we` are all low.
- R8: A `start` pulse while `busy` is high is ignored: it causes no second write and does not alter the instruction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offer `instr` for execution |
| instr | input | 16 | Instruction word |
| bsr | input | 4 | Bank register |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | Instruction in flight |
| ram_addr | output | 12 | Data-memory address |
| ram_re | output | 1 | Read strobe (operand returned next cycle) |
| ram_rdata | input | 8 | Synchronous read data |
| ram_we | output | 1 | Memory write strobe |
| ram_wdata | output | 8 | Memory write data |
| w_we | output | 1 | Working-register write strobe |
| w_data | output | 8 | Working-register write data |
| flag_we | output | 1 | Status flag update strobe |
| c_out | output | 1 | New carry |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |

## Verification
A table of operations covers all four combinations of the destination and bank bits, with carry-in of both 0 and 1. Alternating-bit patterns show whether each bit moves up exactly one place. Operands 0x80 and 0x00 give a zero result, which separates the zero flag from the carry. Quick-bank offsets 0x5F and 0x60 straddle the bank split, and a nonzero bank register confirms it is ignored there. Directed runs cover a foreign opcode and a second start while busy, each of which must produce no write.

// File: rtl/rlcf_pkg.sv
package rlcf_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_CALC  = 2'd2,
      PH_WRITE = 2'd3
   } phase_e;

   localparam logic [5:0] RLCF_OPCODE = 6'b001101;
endpackage

// File: rtl/rlcf_decode.sv
module rlcf_decode #(
   parameter int INSTR_W = 16,
   parameter int DATA_W  = 8
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               is_rlcf,
   output logic               dest_mem,
   output logic               use_bank,
   output logic [DATA_W-1:0]  offset
);
   localparam int OPC_LSB = INSTR_W - 6;

   generate
      if (INSTR_W != DATA_W + 8) begin : g_bad_width
         $error("rlcf_decode: INSTR_W must equal DATA_W + 8");
      end
   endgenerate

   always_comb begin
      is_rlcf  = (instr[INSTR_W-1:OPC_LSB] == rlcf_pkg::RLCF_OPCODE);
      dest_mem = instr[DATA_W+1];
      use_bank = instr[DATA_W];
      offset   = instr[DATA_W-1:0];
   end
endmodule

// File: rtl/rlcf_addr_gen.sv
module rlcf_addr_gen #(
   parameter int          DATA_W       = 8,
   parameter int          BANK_W       = 4,
   parameter bit          HAS_QUICK    = 1'b1,
   parameter int unsigned QUICK_SPLIT  = 32'h60
) (
   input  logic                     use_bank,
   input  logic [BANK_W-1:0]        bsr,
   input  logic [DATA_W-1:0]        offset,
   output logic [BANK_W+DATA_W-1:0] addr
);
   localparam int ADDR_W = BANK_W + DATA_W;

   generate
      if (QUICK_SPLIT > (1 << DATA_W)) begin : g_bad_split
         $error("rlcf_addr_gen: QUICK_SPLIT exceeds offset range");
      end
      if (HAS_QUICK) begin : g_quick
         logic [BANK_W-1:0] quick_bank;
         always_comb begin
            quick_bank = (32'(offset) < QUICK_SPLIT) ? '0 : '1;
            addr = use_bank ? {bsr, offset} : {quick_bank, offset};
         end
      end else begin : g_banked
         always_comb addr = {bsr, offset};
      end
   endgenerate

   // Quick-bank accesses only land in the lowest or highest bank
   always_comb begin
      if (HAS_QUICK && !use_bank)
         AST_QUICK_BANK_EDGE: assert (addr[ADDR_W-1:DATA_W] == '0 || addr[ADDR_W-1:DATA_W] == '1); // R4
   end
endmodule

// File: rtl/rlcf_rotator.sv
module rlcf_rotator #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] operand,
   input  logic              cin,
   output logic [DATA_W-1:0] result,
   output logic              cout
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("rlcf_rotator: DATA_W must be at least 2");
      end
      for (genvar i = 1; i < DATA_W; i++) begin : g_shift
         assign result[i] = operand[i-1];
      end
   endgenerate

   assign result[0] = cin;
   assign cout      = operand[DATA_W-1];
endmodule

// File: rtl/rlcf_seq.sv
module rlcf_seq #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_req,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              dest_mem_in,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] rot_result,
   input  logic              rot_cout,
   output logic              busy,
   output logic              carry_q,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_re,
   output logic              ram_we,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              w_we,
   output logic [DATA_W-1:0] w_data,
   output logic              flag_we,
   output logic              c_out,
   output logic              n_out,
   output logic              z_out
);
   import rlcf_pkg::*;

   phase_e            phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic              dest_mem_q;
   logic [DATA_W-1:0] res_q;
   logic              c_q, n_q, z_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         addr_q     <= '0;
         dest_mem_q <= 1'b0;
         carry_q    <= 1'b0;
         res_q      <= '0;
         c_q        <= 1'b0;
         n_q        <= 1'b0;
         z_q        <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (accept_req) begin
               addr_q     <= addr_in;
               dest_mem_q <= dest_mem_in;
               carry_q    <= carry_in;
               phase_q    <= PH_READ;
            end
            PH_READ: phase_q <= PH_CALC;
            PH_CALC: begin
               res_q   <= rot_result;
               c_q     <= rot_cout;
               n_q     <= rot_result[DATA_W-1];
               z_q     <= (rot_result == '0);
               phase_q <= PH_WRITE;
            end
            PH_WRITE: phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (phase_q != PH_IDLE);
      ram_addr  = addr_q;
      ram_re    = (phase_q == PH_READ);
      flag_we   = (phase_q == PH_WRITE);
      ram_we    = flag_we && dest_mem_q;
      w_we      = flag_we && !dest_mem_q;
      ram_wdata = res_q;
      w_data    = res_q;
      c_out     = c_q;
      n_out     = n_q;
      z_out     = z_q;
   end

   AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_we, w_we})); // R3
   AST_FLAGS_WITH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (ram_we || w_we)); // R6
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> !flag_we); // R6
   AST_CARRY_FROM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (c_out == $past(ram_rdata[DATA_W-1]))); // R2
   AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (z_out == (ram_wdata == '0))); // R5
   AST_NEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (n_out == w_data[DATA_W-1])); // R5
   AST_WRITE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $stable(ram_addr)); // R4
   AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ram_re); // R6
endmodule

// File: rtl/rlcf_unit.sv
module rlcf_unit #(
   parameter int          DATA_W      = 8,
   parameter int          BANK_W      = 4,
   parameter int          INSTR_W     = 16,
   parameter bit          HAS_QUICK   = 1'b1,
   parameter int unsigned QUICK_SPLIT = 32'h60,
   localparam int         ADDR_W      = BANK_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [INSTR_W-1:0] instr,
   input  logic [BANK_W-1:0]  bsr,
   input  logic               carry_in,
   output logic               busy,
   output logic [ADDR_W-1:0]  ram_addr,
   output logic               ram_re,
   input  logic [DATA_W-1:0]  ram_rdata,
   output logic               ram_we,
   output logic [DATA_W-1:0]  ram_wdata,
   output logic               w_we,
   output logic [DATA_W-1:0]  w_data,
   output logic               flag_we,
   output logic               c_out,
   output logic               n_out,
   output logic               z_out
);
   logic              is_rlcf, dest_mem, use_bank;
   logic [DATA_W-1:0] offset;
   logic [ADDR_W-1:0] addr_new;
   logic              accept_req;
   logic              carry_q;
   logic [DATA_W-1:0] rot_result;
   logic              rot_cout;

   rlcf_decode #(.INSTR_W(INSTR_W), .DATA_W(DATA_W)) decode_i (
      .instr    (instr),
      .is_rlcf  (is_rlcf),
      .dest_mem (dest_mem),
      .use_bank (use_bank),
      .offset   (offset)
   );

   rlcf_addr_gen #(
      .DATA_W(DATA_W), .BANK_W(BANK_W),
      .HAS_QUICK(HAS_QUICK), .QUICK_SPLIT(QUICK_SPLIT)
   ) addr_i (
      .use_bank (use_bank),
      .bsr      (bsr),
      .offset   (offset),
      .addr     (addr_new)
   );

   assign accept_req = start && !busy && is_rlcf;

   rlcf_rotator #(.DATA_W(DATA_W)) rot_i (
      .operand (ram_rdata),
      .cin     (carry_q),
      .result  (rot_result),
      .cout    (rot_cout)
   );

   rlcf_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_req  (accept_req),
      .addr_in     (addr_new),
      .dest_mem_in (dest_mem),
      .carry_in    (carry_in),
      .ram_rdata   (ram_rdata),
      .rot_result  (rot_result),
      .rot_cout    (rot_cout),
      .busy        (busy),
      .carry_q     (carry_q),
      .ram_addr    (ram_addr),
      .ram_re      (ram_re),
      .ram_we      (ram_we),
      .ram_wdata   (ram_wdata),
      .w_we        (w_we),
      .w_data      (w_data),
      .flag_we     (flag_we),
      .c_out       (c_out),
      .n_out       (n_out),
      .z_out       (z_out)
   );

   AST_FOREIGN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(start && is_rlcf)) |=> !busy); // R1
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !flag_we) |=> $stable(ram_addr)); // R8
endmodule

// File: tb/rlcf_unit_tb_top.sv
module rlcf_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic [3:0]  bsr = '0;
   logic        carry_in = 1'b0;
   logic        busy, ram_re, ram_we, w_we, flag_we, c_out, n_out, z_out;
   logic [11:0] ram_addr;
   logic [7:0]  ram_rdata, ram_wdata, w_data;

   logic        pre_we = 1'b0;
   logic [11:0] pre_addr = '0;
   logic [7:0]  pre_data = '0;
   logic [7:0]  mem [4096];

   int tests = 0;
   int fails = 0;
   int wr_count = 0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (pre_we) mem[pre_addr] <= pre_data;
      else if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
   end

   always @(posedge clk) if (ram_we || w_we) wr_count <= wr_count + 1;

   rlcf_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .bsr(bsr),
      .carry_in(carry_in), .busy(busy), .ram_addr(ram_addr), .ram_re(ram_re),
      .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .w_we(w_we), .w_data(w_data), .flag_we(flag_we),
      .c_out(c_out), .n_out(n_out), .z_out(z_out)
   );

   // {d, a, bsr[4], f[8], operand[8], cin, result[8], cout, addr[12]}
   localparam int NV = 8;
   localparam logic [43:0] VEC [NV] = '{
      {1'b1, 1'b1, 4'h3, 8'h10, 8'hE6, 1'b0, 8'hCC, 1'b1, 12'h310},
      {1'b0, 1'b1, 4'h2, 8'h44, 8'h81, 1'b1, 8'h03, 1'b1, 12'h244},
      {1'b1, 1'b0, 4'h7, 8'h20, 8'h55, 1'b0, 8'hAA, 1'b0, 12'h020},
      {1'b0, 1'b0, 4'h7, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 12'hF80},
      {1'b1, 1'b0, 4'h9, 8'h5F, 8'h7F, 1'b1, 8'hFF, 1'b0, 12'h05F},
      {1'b1, 1'b0, 4'h9, 8'h60, 8'h01, 1'b0, 8'h02, 1'b0, 12'hF60},
      {1'b1, 1'b1, 4'hF, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b0, 12'hFFF},
      {1'b0, 1'b1, 4'h1, 8'h00, 8'hFF, 1'b1, 8'hFF, 1'b1, 12'h100}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic preload(input logic [11:0] a, input logic [7:0] v);
      @(negedge clk);
      pre_we = 1'b1; pre_addr = a; pre_data = v;
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   task automatic issue(input logic [15:0] iw, input logic [3:0] b, input logic ci);
      @(negedge clk);
      instr = iw; bsr = b; carry_in = ci; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #400000;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h5A;
      repeat (3) @(negedge clk);
      // R7: reset state
      check(!busy && !ram_re && !ram_we && !w_we && !flag_we, "R7", "idle strobes",
            {busy, ram_re, ram_we, w_we, flag_we}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic d, a, cin, cexp;
         logic [3:0]  b;
         logic [7:0]  f, op, rexp;
         logic [11:0] aexp;
         int k;
         int w0;
         {d, a, b, f, op, cin, rexp, cexp, aexp} = VEC[v];
         preload(aexp, op);
         w0 = wr_count;
         issue({6'b001101, d, a, f}, b, cin);
         // negedge after accept edge is the read cycle
         k = 1;
         check(ram_re && ram_addr == aexp, "R4", "read address", ram_addr, aexp);
         while (!flag_we && k < 10) begin @(negedge clk); k++; end
         check(k == 3, "R6", "write cycle", k, 3);
         check(c_out == cexp, "R2", "carry out", c_out, cexp);
         check(n_out == rexp[7], "R5", "negative", n_out, rexp[7]);
         check(z_out == (rexp == 8'h00), "R5", "zero", z_out, rexp == 8'h00);
         if (d) begin
            check(ram_we && !w_we && ram_addr == aexp, "R3", "mem dest strobes",
                  {ram_we, w_we}, 2);
            check(ram_wdata == rexp, "R2", "mem result", ram_wdata, rexp);
         end else begin
            check(w_we && !ram_we, "R3", "W dest strobes", {ram_we, w_we}, 1);
            check(w_data == rexp, "R2", "W result", w_data, rexp);
         end
         @(negedge clk);
         check(!flag_we && !busy, "R6", "single pulse", {flag_we, busy}, 0);
         check(mem[aexp] == (d ? rexp : op), "R3", "memory content", mem[aexp],
               d ? rexp : op);
         check(wr_count == w0 + 1, "R3", "write count", wr_count, w0 + 1);
      end

      // R1: foreign opcode (0011 00..) is ignored
      begin
         int w0;
         w0 = wr_count;
         issue(16'b0011_0011_0001_0000, 4'h3, 1'b1);
         check(!busy, "R1", "busy after foreign", busy, 0);
         repeat (5) @(negedge clk);
         check(wr_count == w0 && !flag_we, "R1", "foreign writes", wr_count, w0);
         check(mem[12'h310] == 8'hCC, "R1", "memory untouched", mem[12'h310], 8'hCC);
      end

      // R8: second start while busy is ignored
      begin
         int w0;
         preload(12'h2A0, 8'h40);
         preload(12'h2B0, 8'h11);
         w0 = wr_count;
         issue({6'b001101, 1'b1, 1'b1, 8'hA0}, 4'h2, 1'b0);
         instr = {6'b001101, 1'b1, 1'b1, 8'hB0}; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (6) @(negedge clk);
         check(wr_count == w0 + 1, "R8", "write count", wr_count, w0 + 1);
         check(mem[12'h2A0] == 8'h80, "R8", "first target", mem[12'h2A0], 8'h80);
         check(mem[12'h2B0] == 8'h11, "R8", "second target", mem[12'h2B0], 8'h11);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule